// File: doc/BRIEF.md
# Sampler Acquisition Control Register File

This block is the control register file of a logic-analyzer sampling engine. A host reaches it with single-register accesses, each carrying an 8-bit address and 8-bit data. Through it the host sets a 16-bit channel-enable mask, a sample-rate divisor and a base-clock choice, then starts and stops acquisition. The block reports a running flag and a sticky FIFO-overflow flag.

Divisor, mode and channel writes land in shadow copies. They reach the active copies, which drive the sampling engine, only when the host raises the update bit in the status/control register. The block also makes the sample strobe. Each of the two base clocks arrives as a one-cycle tick enable in the system clock domain. The strobe is a one-cycle pulse once every divisor+1 ticks of the chosen base clock, and it appears only while running.

Top module: `acq_ctrl`

## Requirements
- R1: A read of address 7 returns the VERSION parameter (default 0x41; legal values 0x10, 0x13, 0x40, 0x41) on `rdata` in the cycle after `rd_en`.
- R2: Writes to address 1 (channel mask bits 7:0), address 6 (channel mask bits 15:8), address 11 (divisor) and address 4 (mode) go to shadow copies. A read of any of these addresses returns the shadow value. `ch_enable` and `clk_sel` do not change until an update.
- R3: A write to address 15 with bit 3 (mask 0x08) set, when the previous status write had bit 3 clear, copies all shadow settings to the active copies. A second such write with bit 3 still set copies nothing.
- R4: A status read (address 15) returns bit 4 (0x10) as constant 1, bit 2 (0x04) as last written, bit 3 as 0, bit 5 (0x20) as the running flag and bit 0 (0x01) as overflow. The sequence 0x0C then 0x04 therefore reads back as 0x14.
- R5: Writing 0x00 to status clears running. A later status read, with bit 0 masked, returns 0x10.
- R6: `fifo_full` high while running sets overflow (status bit 0). Overflow stays set after a stop and is not changed by host writes to bit 0. It is cleared only when a status write starts a new acquisition, that is, sets bit 5 while not running.
- R7: `fifo_full` while not running does not set overflow.
- R8: While running, `sample_strobe` pulses once every divisor+1 ticks of the selected base clock. Mode bit 2 (0x04) set selects `tick_b`; clear selects `tick_a`. The active value of that bit drives `clk_sel`.
- R9: `sample_strobe` stays low in every cycle that follows a cycle with running low.
- R10: An access to any other address reads 0 and writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_a | input | 1 | Tick enable of base clock 0 |
| tick_b | input | 1 | Tick enable of base clock 1 |
| fifo_full | input | 1 | Sample FIFO full indication |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 8 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid the cycle after rd_en |
| running | output | 1 | Acquisition running flag |
| clk_sel | output | 1 | Active base-clock select |
| ch_enable | output | 16 | Active channel-enable mask |
| sample_strobe | output | 1 | One-cycle sample pulse |

## Verification
The assertions assume that `tick_a` and `tick_b` are single-cycle enables already synchronous to `clk`. They assume `fifo_full` is a level in the same domain, and that host reads and writes never fall in the same cycle. The stimulus drives every input on the falling edge. It keeps read and write strobes in separate cycles, and it generates `tick_b` from a free counter as one pulse in every three cycles while `tick_a` is held high. Strobe periods are then exact cycle counts that the bench predicts from the divisor alone.

// File: rtl/acq_pkg.sv
// Package: shared register addresses and status bit positions of the
// acquisition control block. Assumes 8-bit host addresses and data.
package acq_pkg;
    localparam int AW = 8;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_CH_LO   = 8'd1;
    localparam logic [AW-1:0] A_MODE    = 8'd4;
    localparam logic [AW-1:0] A_CH_HI   = 8'd6;
    localparam logic [AW-1:0] A_VERSION = 8'd7;
    localparam logic [AW-1:0] A_DIV     = 8'd11;
    localparam logic [AW-1:0] A_STATUS  = 8'd15;

    localparam int B_OVF   = 0;
    localparam int B_AUXW  = 2;
    localparam int B_UPD   = 3;
    localparam int B_READY = 4;
    localparam int B_RUN   = 5;

    localparam int M_CLKSEL = 2;

    typedef struct packed {
        logic [15:0]   ch;
        logic [DW-1:0] div;
        logic [DW-1:0] mode;
    } acq_cfg_t;
endpackage

// File: rtl/acq_regs.sv
// Module: register decode, shadow/active settings and status flags.
// Assumes reads and writes are not issued in the same cycle.
module acq_regs
    import acq_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          fifo_full,
    output logic [DW-1:0] rdata,
    output acq_cfg_t      active,
    output logic          running,
    output logic          ovf,
    output logic          commit
);
    acq_cfg_t shadow;
    logic     aux_q;
    logic     upd_q;
    logic     stat_wr;
    logic     start;

    assign stat_wr = wr_en && (addr == A_STATUS);
    assign commit  = stat_wr && wdata[B_UPD] && !upd_q;
    assign start   = stat_wr && wdata[B_RUN] && !running;

    // Shadow settings capture host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CH_LO: shadow.ch[7:0]  <= wdata;
                A_CH_HI: shadow.ch[15:8] <= wdata;
                A_DIV:   shadow.div      <= wdata;
                A_MODE:  shadow.mode     <= wdata;
                default: ;
            endcase
        end
    end

    // Active settings load from shadow on a rising update bit.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else if (commit) active <= shadow;
    end

    // Status/control fields written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            aux_q   <= 1'b0;
            upd_q   <= 1'b0;
        end else if (stat_wr) begin
            running <= wdata[B_RUN];
            aux_q   <= wdata[B_AUXW];
            upd_q   <= wdata[B_UPD];
        end
    end

    // Sticky overflow, cleared when a new run begins.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else if (start) ovf <= 1'b0;
        else if (running && fifo_full) ovf <= 1'b1;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_VERSION: rdata <= VERSION;
                A_CH_LO:   rdata <= shadow.ch[7:0];
                A_CH_HI:   rdata <= shadow.ch[15:8];
                A_DIV:     rdata <= shadow.div;
                A_MODE:    rdata <= shadow.mode;
                A_STATUS: begin
                    rdata         <= '0;
                    rdata[B_OVF]  <= ovf;
                    rdata[B_AUXW] <= aux_q;
                    rdata[B_READY] <= 1'b1;
                    rdata[B_RUN]  <= running;
                end
                default:   rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/acq_divider.sv
// Module: sample strobe generator. Counts ticks of the selected base
// clock and pulses once every div+1 ticks. Assumes ticks are clk-synchronous.
module acq_divider #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            sel,
    input  logic            tick_a,
    input  logic            tick_b,
    input  logic [DIVW-1:0] div,
    output logic            strobe,
    output logic            tick_sel
);
    logic [DIVW-1:0] cnt;
    logic            wrap;

    assign tick_sel = sel ? tick_b : tick_a;
    assign wrap     = (cnt >= div);

    // Tick counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick_sel) cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // One-cycle strobe on the wrapping tick.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else strobe <= run && tick_sel && wrap;
    end
endmodule

// File: rtl/acq_ctrl.sv
// Module: top of the acquisition control block; ties the register file
// to the strobe divider. Assumes a single clock with base clocks as ticks.
module acq_ctrl
    import acq_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic        fifo_full,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        running,
    output logic        clk_sel,
    output logic [15:0] ch_enable,
    output logic        sample_strobe
);
    acq_cfg_t active;
    logic     ovf;
    logic     commit;
    logic     tick_sel;

    acq_regs #(.VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .fifo_full(fifo_full),
        .rdata(rdata), .active(active), .running(running),
        .ovf(ovf), .commit(commit)
    );

    assign clk_sel   = active.mode[M_CLKSEL];
    assign ch_enable = active.ch;

    acq_divider #(.DIVW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(running), .sel(clk_sel),
        .tick_a(tick_a), .tick_b(tick_b), .div(active.div),
        .strobe(sample_strobe), .tick_sel(tick_sel)
    );
endmodule

// File: rtl/acq_ctrl_chk.sv
// Module: property checker for acq_ctrl, attached by bind.
// Assumes inputs are synchronous to clk.
module acq_ctrl_chk #(
    parameter logic [7:0] VERSION = 8'h41
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [7:0]  addr,
    input logic [7:0]  rdata,
    input logic        running,
    input logic        fifo_full,
    input logic        ovf,
    input logic        commit,
    input logic        tick_sel,
    input logic [15:0] ch_enable,
    input logic        sample_strobe
);
    p_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'd7) |=> (rdata == VERSION));
    p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ch_enable));
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fifo_full) |=> ovf);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (ovf || running));
    p_strobe_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> $past(tick_sel));
    p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !sample_strobe);
endmodule

bind acq_ctrl acq_ctrl_chk #(.VERSION(VERSION)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .running(running), .fifo_full(fifo_full), .ovf(ovf), .commit(commit),
    .tick_sel(tick_sel), .ch_enable(ch_enable), .sample_strobe(sample_strobe)
);

// File: tb/tb_acq_ctrl.sv
module tb_acq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b1;
    logic        tick_b = 1'b0;
    logic        fifo_full = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        running;
    logic        clk_sel;
    logic [15:0] ch_enable;
    logic        sample_strobe;

    int checks = 0;
    int errors = 0;
    int phase = 0;

    acq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .fifo_full(fifo_full), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .running(running), .clk_sel(clk_sel),
        .ch_enable(ch_enable), .sample_strobe(sample_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick_b: one pulse every third cycle, changed on falling edges
    always @(negedge clk) begin
        phase  <= (phase == 2) ? 0 : phase + 1;
        tick_b <= (phase == 2);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic period(output int p);
        int n = 0;
        while (!sample_strobe && n < 3000) begin @(negedge clk); n++; end
        @(negedge clk);
        p = 1;
        while (!sample_strobe && p < 3000) begin @(negedge clk); p++; end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R4 reset running", running, 0);
        check("R2 reset ch_enable", ch_enable, 0);
        check("R9 reset strobe", sample_strobe, 0);
        rd(8'd15, d);
        check("R4 reset status", d, 8'h10);
    endtask

    task automatic t_version();
        logic [7:0] d;
        rd(8'd7, d);
        check("R1 version", d, 8'h41);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(8'h20, 8'hFF);
        rd(8'h20, d);
        check("R10 unmapped read", d, 0);
        rd(8'd15, d);
        check("R10 status untouched", d, 8'h10);
        check("R10 running untouched", running, 0);
    endtask

    task automatic t_shadow_update();
        logic [7:0] d;
        wr(8'd1, 8'hA5); wr(8'd6, 8'h3C); wr(8'd11, 8'd3); wr(8'd4, 8'h00);
        rd(8'd1, d);
        check("R2 shadow ch low readback", d, 8'hA5);
        rd(8'd11, d);
        check("R2 shadow div readback", d, 3);
        check("R2 active unchanged", ch_enable, 0);
        wr(8'd15, 8'h0C);
        check("R3 update commits", ch_enable, 16'h3CA5);
        rd(8'd15, d);
        check("R4 update bit reads 0", d, 8'h14);
        wr(8'd15, 8'h04);
        rd(8'd15, d);
        check("R4 setup readback", d, 8'h14);
        // second raise without a clear in between
        wr(8'd1, 8'h11); wr(8'd15, 8'h0C);
        check("R3 commit low byte", ch_enable, 16'h3C11);
        wr(8'd1, 8'h22); wr(8'd15, 8'h0C);
        check("R3 held update no commit", ch_enable, 16'h3C11);
        wr(8'd15, 8'h04);
    endtask

    task automatic t_strobe();
        int p;
        wr(8'd15, 8'h24);
        check("R4 running set", running, 1);
        period(p);
        check("R8 period tick_a div3", p, 4);
        wr(8'd4, 8'h04); wr(8'd11, 8'd1);
        check("R2 clk_sel before update", clk_sel, 0);
        wr(8'd15, 8'h2C); wr(8'd15, 8'h24);
        check("R8 clk_sel active", clk_sel, 1);
        period(p);
        period(p);
        check("R8 period tick_b div1", p, 6);
    endtask

    task automatic t_stop_ovf();
        logic [7:0] d;
        int n = 0;
        @(negedge clk); fifo_full = 1'b1;
        @(negedge clk); fifo_full = 1'b0;
        wr(8'd15, 8'h00);
        check("R5 stopped", running, 0);
        repeat (30) begin @(negedge clk); if (sample_strobe) n++; end
        check("R9 no strobe idle", n, 0);
        rd(8'd15, d);
        check("R5 stop readback masked", d & 8'hFE, 8'h10);
        check("R6 overflow sticky", d[0], 1);
        wr(8'd15, 8'h00);
        rd(8'd15, d);
        check("R6 write bit0 ignored", d[0], 1);
        wr(8'd15, 8'h24);
        rd(8'd15, d);
        check("R6 cleared on start", d[0], 0);
        wr(8'd15, 8'h00);
        @(negedge clk); fifo_full = 1'b1;
        repeat (3) @(negedge clk);
        fifo_full = 1'b0;
        rd(8'd15, d);
        check("R7 idle full no overflow", d, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_version();
        t_unmapped();
        t_shadow_update();
        t_strobe();
        t_stop_ovf();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule